// File: doc/BRIEF.md
# Packet Receive Deframer with Dual-Seed CRC16

This block sits behind the correlator of a spread-spectrum radio receiver. It watches per-symbol strobes that say whether a symbol matched the start-of-packet code, matched the body code, or matched neither. It also takes the bytes the demodulator assembles, one per valid strobe. The block finds the start of a packet, sorts the following bytes into payload and trailing checksum, and reports where the packet ends. It also reports whether the checksum held and whether the packet was too long.

A packet can end in one of two ways. In counted mode, the first byte after the start marker gives the payload size, and the checksum bytes follow the payload. In quiet mode, the packet ends after a configurable run of symbols that matched nothing. In quiet mode the last two bytes received are taken as the checksum. The checksum is accepted when it equals a CRC16 computed from the configured seed, or one computed from a zero seed. Two engines compute both values in parallel as the payload goes by.

Top module: `pkt_deframer`

## Requirements
- R1: After reset, pay_valid, pkt_done, crc_ok and len_err are all low, and the block is hunting for a start of packet.
- R2: With cfg_framing_en high, a start of packet is recognised on the second of two consecutive symbol strobes that are both sym_sop. Any other symbol strobe between them restarts the count.
- R3: With cfg_framing_en low, a start of packet is recognised on the second of two consecutive sym_corr strobes.
- R4: Counted mode applies when cfg_framing_en and cfg_len_en are both high. In this mode the first byte after the start is the payload count. Each of the next count bytes appears on pay_data with pay_valid high, one cycle after its byte_valid.
- R5: In counted mode, pkt_done pulses for one cycle, one cycle after the last byte of the packet. With cfg_crc_en high, that last byte is the second byte after the payload. With cfg_crc_en low, it is the last payload byte, or the count byte when the count is 0.
- R6: In counted mode, a count byte above MAX_LEN (40) pulses len_err for one cycle. The packet is then dropped without pkt_done, and the block returns to hunting.
- R7: Quiet mode applies whenever counted mode does not. In this mode, pkt_done pulses one cycle after the cfg_quiet_lim-th consecutive sym_nocorr; a limit of 0 acts as 1. A sym_corr or sym_sop strobe restarts the run. With cfg_crc_en high, the last two bytes are the checksum and never appear on pay_data.
- R8: The CRC16 uses the polynomial 0x8005, bit-reflected (0xA001), fed least significant bit first. It covers the payload bytes only and has no final inversion. The received value is taken low byte first. crc_ok is high together with pkt_done only when cfg_crc_en is high and the received value equals the CRC from cfg_seed or the CRC from seed 0.
- R9: In quiet mode, a payload byte that would be the 41st pulses len_err instead of being emitted. The packet is then dropped without pkt_done.
- R10: Bytes that arrive while hunting are ignored and produce no pay_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_framing_en | input | 1 | Start marker uses the start code (1) or two body correlations (0) |
| cfg_len_en | input | 1 | Use the in-band count byte (only with framing) |
| cfg_crc_en | input | 1 | Trailing CRC16 present and checked |
| cfg_seed | input | 16 | Configured CRC seed |
| cfg_quiet_lim | input | 8 | Non-correlation run that ends a packet in quiet mode |
| sym_sop | input | 1 | Symbol strobe: matched start code |
| sym_corr | input | 1 | Symbol strobe: matched body code |
| sym_nocorr | input | 1 | Symbol strobe: no correlation |
| byte_valid | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| pay_valid | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte |
| pkt_done | output | 1 | One-cycle end-of-packet pulse |
| crc_ok | output | 1 | Checksum accepted, valid with pkt_done |
| len_err | output | 1 | One-cycle length violation pulse |

## Verification
The hardest case to reach is a quiet-mode packet that ends correctly even though a non-correlation run started and then broke off. That path exercises both the restart of the run counter and the two-byte holdback that keeps the checksum off the payload output. To reach it, the random stimulus often sends a run one short of the limit, then a correlation, and only then the full run. It also draws the checksum from the configured seed, the zero seed or a corrupted value. Directed cases cover an interrupted start marker, a count of 40 against 41, a 41st quiet-mode byte, and a zero limit.

// File: rtl/pkt_deframer_pkg.sv
package pkt_deframer_pkg;

  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;  // 0x8005 bit-reflected

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_LEN,
    ST_BODY,
    ST_CRC,
    ST_FREE
  } dfr_state_e;

  // One byte through the reflected CRC16, LSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // Accept the received value against either seed.
  function automatic logic crc_pass(input logic [15:0] rx, input logic [15:0] a,
                                    input logic [15:0] b);
    return (rx == a) || (rx == b);
  endfunction

endpackage

// File: rtl/pdf_sop_hunt.sv
module pdf_sop_hunt (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic framing_en,
  input  logic sym_sop,
  input  logic sym_corr,
  input  logic sym_nocorr,
  output logic found
);
  logic want, other, seen_one;

  always_comb begin
    want  = framing_en ? sym_sop : sym_corr;
    other = (sym_sop | sym_corr | sym_nocorr) & ~want;
    found = enable & want & seen_one;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) seen_one <= 1'b0;
    else if (want)         seen_one <= ~seen_one;
    else if (other)        seen_one <= 1'b0;
  end
endmodule

// File: rtl/pdf_quiet_run.sv
module pdf_quiet_run #(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          hit,
  input  logic          miss,
  input  logic [QW-1:0] limit,
  output logic          ended
);
  logic [QW-1:0] run;
  logic [QW:0]   next_run, lim_eff;

  always_comb begin
    lim_eff  = (limit == '0) ? (QW+1)'(1) : {1'b0, limit};
    next_run = {1'b0, run} + (QW+1)'(1);
    ended    = active & miss & ~hit & (next_run >= lim_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active || hit) run <= '0;
    else if (miss)                run <= next_run[QW-1:0];
  end
endmodule

// File: rtl/pdf_crc_pair.sv
module pdf_crc_pair
  import pkt_deframer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic [15:0] seed,
  input  logic        feed,
  input  logic [7:0]  data,
  output logic [15:0] crc_cfg,
  output logic [15:0] crc_zero
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_cfg  <= '0;
      crc_zero <= '0;
    end else if (init) begin
      crc_cfg  <= seed;
      crc_zero <= '0;
    end else if (feed) begin
      crc_cfg  <= crc16_step(crc_cfg, data);
      crc_zero <= crc16_step(crc_zero, data);
    end
  end
endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
  import pkt_deframer_pkg::*;
#(
  parameter int MAX_LEN = 40,
  parameter int QW      = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_framing_en,
  input  logic          cfg_len_en,
  input  logic          cfg_crc_en,
  input  logic [15:0]   cfg_seed,
  input  logic [QW-1:0] cfg_quiet_lim,
  input  logic          sym_sop,
  input  logic          sym_corr,
  input  logic          sym_nocorr,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  output logic          pay_valid,
  output logic [7:0]    pay_data,
  output logic          pkt_done,
  output logic          crc_ok,
  output logic          len_err
);
  dfr_state_e       state;
  logic             in_hunt, counted_mode;
  logic             sop_found, quiet_end;
  logic [15:0]      crc_cfg, crc_zero;
  logic [LEN_W-1:0] len_left, pay_cnt;
  logic [1:0]       hcnt;
  logic [7:0]       h_lo, h_hi, rx_lo;
  logic             crc_idx;
  logic             emit_req, over_len, crc_feed;
  logic [7:0]       emit_data;

  assign in_hunt      = (state == ST_HUNT);
  assign counted_mode = cfg_framing_en & cfg_len_en;

  pdf_sop_hunt u_hunt (
    .clk(clk), .rst_n(rst_n), .enable(in_hunt), .framing_en(cfg_framing_en),
    .sym_sop(sym_sop), .sym_corr(sym_corr), .sym_nocorr(sym_nocorr), .found(sop_found)
  );

  pdf_quiet_run #(.QW(QW)) u_quiet (
    .clk(clk), .rst_n(rst_n), .active(state == ST_FREE), .hit(sym_corr | sym_sop),
    .miss(sym_nocorr), .limit(cfg_quiet_lim), .ended(quiet_end)
  );

  pdf_crc_pair u_crc (
    .clk(clk), .rst_n(rst_n), .init(sop_found), .seed(cfg_seed),
    .feed(crc_feed), .data(emit_data), .crc_cfg(crc_cfg), .crc_zero(crc_zero)
  );

  // Which byte, if any, leaves as payload this cycle.
  always_comb begin
    emit_req  = 1'b0;
    emit_data = byte_data;
    if (state == ST_BODY) begin
      emit_req = byte_valid;
    end else if (state == ST_FREE) begin
      emit_req  = byte_valid & ~quiet_end & (~cfg_crc_en | (hcnt == 2'd2));
      emit_data = cfg_crc_en ? h_lo : byte_data;
    end
    over_len = emit_req & (state == ST_FREE) & (pay_cnt == LEN_W'(MAX_LEN));
    crc_feed = emit_req & ~over_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_HUNT;
      pay_valid <= 1'b0;
      pay_data  <= '0;
      pkt_done  <= 1'b0;
      crc_ok    <= 1'b0;
      len_err   <= 1'b0;
      len_left  <= '0;
      pay_cnt   <= '0;
      hcnt      <= '0;
      h_lo      <= '0;
      h_hi      <= '0;
      rx_lo     <= '0;
      crc_idx   <= 1'b0;
    end else begin
      pay_valid <= 1'b0;
      pkt_done  <= 1'b0;
      crc_ok    <= 1'b0;
      len_err   <= 1'b0;
      if (crc_feed) begin
        pay_valid <= 1'b1;
        pay_data  <= emit_data;
        pay_cnt   <= pay_cnt + LEN_W'(1);
      end
      case (state)
        ST_HUNT: if (sop_found) begin
          state   <= counted_mode ? ST_LEN : ST_FREE;
          pay_cnt <= '0;
          hcnt    <= '0;
          crc_idx <= 1'b0;
        end
        ST_LEN: if (byte_valid) begin
          if (byte_data > 8'(MAX_LEN)) begin
            len_err <= 1'b1;
            state   <= ST_HUNT;
          end else begin
            len_left <= byte_data[LEN_W-1:0];
            if (byte_data != 8'd0)  state <= ST_BODY;
            else if (cfg_crc_en)    state <= ST_CRC;
            else begin
              pkt_done <= 1'b1;
              state    <= ST_HUNT;
            end
          end
        end
        ST_BODY: if (byte_valid) begin
          len_left <= len_left - LEN_W'(1);
          if (len_left == LEN_W'(1)) begin
            if (cfg_crc_en) state <= ST_CRC;
            else begin
              pkt_done <= 1'b1;
              state    <= ST_HUNT;
            end
          end
        end
        ST_CRC: if (byte_valid) begin
          if (!crc_idx) begin
            rx_lo   <= byte_data;
            crc_idx <= 1'b1;
          end else begin
            pkt_done <= 1'b1;
            crc_ok   <= crc_pass({byte_data, rx_lo}, crc_cfg, crc_zero);
            state    <= ST_HUNT;
          end
        end
        ST_FREE: begin
          if (quiet_end) begin
            pkt_done <= 1'b1;
            crc_ok   <= cfg_crc_en && (hcnt == 2'd2) &&
                        crc_pass({h_hi, h_lo}, crc_cfg, crc_zero);
            state    <= ST_HUNT;
          end else if (over_len) begin
            len_err <= 1'b1;
            state   <= ST_HUNT;
          end else if (byte_valid && cfg_crc_en) begin
            if (hcnt == 2'd2) begin
              h_lo <= h_hi;
              h_hi <= byte_data;
            end else begin
              if (hcnt == 2'd0) h_lo <= byte_data;
              else              h_hi <= byte_data;
              hcnt <= hcnt + 2'd1;
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/pkt_deframer_chk.sv
module pkt_deframer_chk (
  input logic clk,
  input logic rst_n,
  input logic in_hunt,
  input logic sop_found,
  input logic byte_valid,
  input logic cfg_crc_en,
  input logic pay_valid,
  input logic pkt_done,
  input logic crc_ok,
  input logic len_err
);
  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_done && len_err));  // R6
  AST_OK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> pkt_done);  // R8
  AST_OK_NEEDS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> $past(cfg_crc_en));  // R8
  AST_NO_PAY_FROM_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> !$past(in_hunt));  // R10
  AST_PAY_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> $past(byte_valid));  // R4
  AST_SOP_LEAVES_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    sop_found |=> !in_hunt);  // R2
  AST_END_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done || len_err) |-> in_hunt);  // R5
endmodule

bind pkt_deframer pkt_deframer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_hunt(in_hunt), .sop_found(sop_found),
  .byte_valid(byte_valid), .cfg_crc_en(cfg_crc_en), .pay_valid(pay_valid),
  .pkt_done(pkt_done), .crc_ok(crc_ok), .len_err(len_err)
);

// File: tb/test_pkt_deframer.sv
module test_pkt_deframer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_framing_en = 1'b0, cfg_len_en = 1'b0, cfg_crc_en = 1'b0;
  logic [15:0] cfg_seed = '0;
  logic [7:0]  cfg_quiet_lim = 8'd1;
  logic sym_sop = 1'b0, sym_corr = 1'b0, sym_nocorr = 1'b0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic pay_valid, pkt_done, crc_ok, len_err;
  logic [7:0] pay_data;

  int n_chk = 0, n_fail = 0;
  logic [7:0] pbuf [64];
  logic [7:0] got [64];
  int got_n = 0, done_n = 0, err_n = 0;
  logic ok_seen = 1'b0;

  always #2 clk = ~clk;

  pkt_deframer i_pkt_deframer (.*);

  always @(negedge clk) if (rst_n) begin
    if (pay_valid) begin
      if (got_n < 64) got[got_n] = pay_data;
      got_n++;
    end
    if (pkt_done) begin
      done_n++;
      ok_seen = crc_ok;
    end
    if (len_err) err_n++;
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] seed, input int n);
    logic [15:0] c = seed;
    for (int b = 0; b < n; b++)
      for (int i = 0; i < 8; i++)
        c = (c >> 1) ^ ({16{c[0] ^ pbuf[b][i]}} & 16'hA001);
    return c;
  endfunction

  task automatic sym(input int k);  // 0 sop, 1 corr, 2 nocorr
    @(negedge clk);
    sym_sop = (k == 0); sym_corr = (k == 1); sym_nocorr = (k == 2);
    @(negedge clk);
    sym_sop = 0; sym_corr = 0; sym_nocorr = 0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1; byte_data = b;
    @(negedge clk);
    byte_valid = 0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic clear_mon();
    got_n = 0; done_n = 0; err_n = 0; ok_seen = 0;
  endtask

  // mode 0 counted, 1 quiet; sel 0 cfg seed, 1 zero seed, 2 corrupt
  task automatic run_pkt(input bit quiet, input bit fram, input bit crc, input int n,
                         input int sel, input bit broken_run);
    logic [15:0] tx, a, z;
    bit exp_ok;
    int emit;
    cfg_framing_en = quiet ? fram : 1'b1;
    cfg_len_en = quiet ? (fram ? 1'b0 : 1'($urandom_range(0, 1))) : 1'b1;
    cfg_crc_en = crc;
    cfg_seed = 16'($urandom);
    for (int i = 0; i < n; i++) pbuf[i] = 8'($urandom);
    a = ref_crc(cfg_seed, (n > 40) ? 40 : n);
    z = ref_crc(16'h0000, (n > 40) ? 40 : n);
    tx = (sel == 0) ? a : (sel == 1) ? z : (a ^ 16'h0001);
    if (sel == 2 && tx == z) tx = a ^ 16'h0002;
    exp_ok = crc && (sel != 2);
    clear_mon();
    sym(cfg_framing_en ? 0 : 1);
    sym(cfg_framing_en ? 0 : 1);
    if (!quiet) put_byte(8'(n));
    if (quiet || n <= 40) begin
      for (int i = 0; i < n; i++) put_byte(pbuf[i]);
      if (crc) begin put_byte(tx[7:0]); put_byte(tx[15:8]); end
    end
    if (quiet) begin
      if (broken_run && cfg_quiet_lim > 1) begin
        repeat (cfg_quiet_lim - 1) sym(2);
        sym(1);
      end
      repeat ((cfg_quiet_lim == 0) ? 1 : cfg_quiet_lim) sym(2);
    end
    repeat (3) @(negedge clk);
    if (n > 40) begin
      chk(err_n == 1, quiet ? "R9 len_err" : "R6 len_err", err_n, 1);
      chk(done_n == 0, quiet ? "R9 no done" : "R6 no done", done_n, 0);
      emit = quiet ? 40 : 0;
      chk(got_n == emit, quiet ? "R9 emitted" : "R6 emitted", got_n, emit);
    end else begin
      chk(err_n == 0, "R5 no len_err", err_n, 0);
      chk(done_n == 1, quiet ? "R7 pkt_done" : "R5 pkt_done", done_n, 1);
      chk(got_n == n, quiet ? "R7 payload count" : "R4 payload count", got_n, n);
      for (int i = 0; i < n && i < got_n; i++)
        chk(got[i] == pbuf[i], "R4 payload byte", got[i], pbuf[i]);
      chk(ok_seen == exp_ok, "R8 crc_ok", ok_seen, exp_ok);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    chk(!pay_valid && !pkt_done && !crc_ok && !len_err, "R1 reset outputs",
        {pay_valid, pkt_done, crc_ok, len_err}, 0);
    rst_n = 1;
    @(negedge clk);
    // R10: bytes while hunting are ignored
    clear_mon();
    put_byte(8'h33); put_byte(8'h05);
    repeat (2) @(negedge clk);
    chk(got_n == 0 && done_n == 0, "R10 hunt ignores bytes", got_n, 0);
    // R2: interrupted start marker, then completed
    cfg_framing_en = 1; cfg_len_en = 1; cfg_crc_en = 0;
    clear_mon();
    sym(0); sym(2); sym(0);
    put_byte(8'h01); put_byte(8'hAA);
    repeat (2) @(negedge clk);
    chk(got_n == 0, "R2 broken marker no start", got_n, 0);
    sym(0);
    put_byte(8'h01); put_byte(8'h5C);
    repeat (3) @(negedge clk);
    chk(got_n == 1 && got[0] == 8'h5C, "R2 marker completes", got_n, 1);
    chk(done_n == 1, "R5 done without crc", done_n, 1);
    // R3: framing off, body correlations start the packet
    cfg_quiet_lim = 8'd3;
    run_pkt(1, 0, 1, 5, 0, 0);
    // R5 zero count with and without crc, R4/R6 boundary
    run_pkt(0, 1, 0, 0, 0, 0);
    run_pkt(0, 1, 1, 0, 1, 0);
    run_pkt(0, 1, 1, 40, 0, 0);
    run_pkt(0, 1, 1, 41, 0, 0);
    // R9: quiet mode overlong
    cfg_quiet_lim = 8'd2;
    run_pkt(1, 1, 0, 41, 0, 0);
    // R7: limit 0 behaves as 1
    cfg_quiet_lim = 8'd0;
    run_pkt(1, 1, 1, 3, 2, 0);
    // random mix
    for (int k = 0; k < 60; k++) begin
      cfg_quiet_lim = 8'($urandom_range(1, 5));
      run_pkt(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              $urandom_range(0, 40), $urandom_range(0, 2), 1'($urandom_range(0, 1)));
    end
    finish_run();
  end
endmodule